// File: doc/BRIEF.md
# Printer and GPIO Register Interface

This block is the host-facing register decoder of a small I/O device. It serves a parallel printer port, one 8-bit general-purpose input port and one 8-bit general-purpose output port. The host reaches it over an 8-bit data bus with active-low chip select, write strobe and output enable. Only the low three address bits select a register. Writes are sampled on the rising clock edge while chip select and write are both low. Reads are combinational while chip select and output enable are both low.

Three latches drive the output pins: the general-purpose output port, the printer data byte and the printer control pair (strobe and init). The printer status read returns the busy and fault inputs together with a sticky acknowledge flag. The acknowledge input is synchronised through two flops and captured on its active edge. The flag stays set until the host writes a 1 to the acknowledge-clear bit of the printer control register.

Top module: `prt_gpio_regs`

## Requirements
- R1: The address bit above bit 2 has no effect. A register is reached identically with addr[3] at 0 or at 1, for both reads and writes.
- R2: A read at address 3 returns gpi[7:0].
- R3: A write at address 4 loads gpo from the data bus. gpo does not change in any cycle without such a write.
- R4: A write at address 5 loads prn_data from the data bus. prn_data does not change in any cycle without such a write.
- R5: A write at address 6 sets prn_strobe to data bit 0 and prn_init to data bit 1.
- R6: A read at address 4 returns the printer status: bit 0 is prn_busy, bit 1 is prn_fault and bit 2 is the acknowledge flag. Bits 7:3 read as 0.
- R7: A high-to-low transition on prn_ack_n (active low) sets the acknowledge flag. The flag is visible in the status read after the third rising edge that follows the transition. Holding the input low, or taking it high again, does not set the flag.
- R8: A write at address 6 with data bit 2 at 1 clears the acknowledge flag. The same write with bit 2 at 0 leaves the flag unchanged.
- R9: If a new acknowledge edge and a clear write fall in the same cycle, the flag ends set.
- R10: While rst is high, gpo, prn_data, prn_strobe, prn_init and the acknowledge flag are all 0.
- R11: data_oe is 1 exactly while cs_n and oe_n are both low. data_out is 0 whenever data_oe is 0, and reads of addresses 0, 1, 2, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 4 | Register address; only bits 2:0 decode |
| data_in | input | 8 | Write data from host |
| data_out | output | 8 | Read data to host |
| data_oe | output | 1 | High while the block drives the bus |
| gpi | input | 8 | General-purpose input port |
| gpo | output | 8 | General-purpose output port |
| prn_data | output | 8 | Printer data port |
| prn_strobe | output | 1 | Printer strobe output |
| prn_init | output | 1 | Printer init output |
| prn_busy | input | 1 | Printer busy input |
| prn_fault | input | 1 | Printer fault input |
| prn_ack_n | input | 1 | Printer acknowledge input, active low |

## Verification
Corruption in the decoder or the output latches shows on gpo, prn_data, prn_strobe or prn_init one edge after the offending write. Any spurious change in a cycle without a matching write is flagged at the next edge. A wrong acknowledge flag appears only through the status read at address 4. The bench therefore reads the status in the cycles just before and just after the expected set point. This exposes a wrong synchroniser depth, a wrong edge polarity or a wrong set/clear priority within one cycle.

// File: rtl/prt_gpio_pkg.sv
package prt_gpio_pkg;
   localparam logic [2:0] ADR_GPIN  = 3'd3;
   localparam logic [2:0] ADR_GPOUT = 3'd4;
   localparam logic [2:0] ADR_PSTAT = 3'd4;
   localparam logic [2:0] ADR_PDATA = 3'd5;
   localparam logic [2:0] ADR_PCTL  = 3'd6;

   localparam int PCTL_STROBE = 0;
   localparam int PCTL_INIT   = 1;
   localparam int PCTL_ACKCLR = 2;

   typedef struct packed {
      logic ack;
      logic fault;
      logic busy;
   } pstat_t;
endpackage

// File: rtl/prt_addr_dec.sv
module prt_addr_dec #(
   parameter int DEC_W = 3
) (
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic             oe_n,
   input  logic [DEC_W-1:0] addr_lo,
   output logic             we_gpo,
   output logic             we_pdata,
   output logic             we_pctl,
   output logic             rd_act
);
   import prt_gpio_pkg::*;

   logic wr_act;

   generate
      if (DEC_W != 3) begin : g_bad_dec
         $error("prt_addr_dec: DEC_W must be 3");
      end
   endgenerate

   assign wr_act   = !cs_n && !wr_n;
   assign rd_act   = !cs_n && !oe_n;
   assign we_gpo   = wr_act && (addr_lo == ADR_GPOUT);
   assign we_pdata = wr_act && (addr_lo == ADR_PDATA);
   assign we_pctl  = wr_act && (addr_lo == ADR_PCTL);
endmodule

// File: rtl/prt_out_latch.sv
module prt_out_latch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we_gpo,
   input  logic          we_pdata,
   input  logic          we_pctl,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] gpo,
   output logic [DW-1:0] pdata,
   output logic          strobe,
   output logic          init,
   output logic          ack_clr
);
   import prt_gpio_pkg::*;

   generate
      if (DW < 3) begin : g_bad_dw
         $error("prt_out_latch: DW must be at least 3");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         gpo    <= '0;
         pdata  <= '0;
         strobe <= 1'b0;
         init   <= 1'b0;
      end else begin
         if (we_gpo)   gpo   <= wdata;
         if (we_pdata) pdata <= wdata;
         if (we_pctl) begin
            strobe <= wdata[PCTL_STROBE];
            init   <= wdata[PCTL_INIT];
         end
      end
   end

   assign ack_clr = we_pctl && wdata[PCTL_ACKCLR];

   AST_GPO_HOLD: assert property (@(posedge clk) disable iff (rst)
      !we_gpo |=> $stable(gpo)); // R3
   AST_PDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !we_pdata |=> $stable(pdata)); // R4
   AST_PDATA_LOAD: assert property (@(posedge clk) disable iff (rst)
      we_pdata |=> (pdata == $past(wdata))); // R4
endmodule

// File: rtl/prt_ack_capture.sv
module prt_ack_capture #(
   parameter int SYNC_STAGES    = 2,
   parameter bit ACK_ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ack_pin,
   input  logic clr,
   output logic ack_flag
);
   localparam logic IDLE_LVL = ACK_ACTIVE_LOW ? 1'b1 : 1'b0;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   act_now;
   logic                   act_prev;
   logic                   edge_hit;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("prt_ack_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sync_q <= {SYNC_STAGES{IDLE_LVL}};
         prev_q <= IDLE_LVL;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ack_pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   generate
      if (ACK_ACTIVE_LOW) begin : g_pol_low
         assign act_now  = !sync_q[SYNC_STAGES-1];
         assign act_prev = !prev_q;
      end else begin : g_pol_high
         assign act_now  = sync_q[SYNC_STAGES-1];
         assign act_prev = prev_q;
      end
   endgenerate

   assign edge_hit = act_now && !act_prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)           ack_flag <= 1'b0;
      else if (edge_hit) ack_flag <= 1'b1;
      else if (clr)      ack_flag <= 1'b0;
   end

   AST_ACK_SET: assert property (@(posedge clk) disable iff (rst)
      edge_hit |=> ack_flag); // R9
   AST_ACK_CLR: assert property (@(posedge clk) disable iff (rst)
      (clr && !edge_hit) |=> !ack_flag); // R8
   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!clr && !edge_hit) |=> $stable(ack_flag)); // R7
endmodule

// File: rtl/prt_rd_mux.sv
module prt_rd_mux #(
   parameter int DW    = 8,
   parameter int DEC_W = 3
) (
   input  logic                 rd_act,
   input  logic [DEC_W-1:0]     addr_lo,
   input  logic [DW-1:0]        gpi,
   input  prt_gpio_pkg::pstat_t stat,
   output logic [DW-1:0]        data_out,
   output logic                 data_oe
);
   import prt_gpio_pkg::*;

   localparam int SW = $bits(pstat_t);

   logic [DW-1:0] sel_val;

   always_comb begin
      sel_val = '0;
      case (addr_lo)
         ADR_GPIN:  sel_val = gpi;
         ADR_PSTAT: sel_val = {{(DW-SW){1'b0}}, stat};
         default:   sel_val = '0;
      endcase
   end

   assign data_oe  = rd_act;
   assign data_out = rd_act ? sel_val : '0;
endmodule

// File: rtl/prt_gpio_regs.sv
module prt_gpio_regs #(
   parameter int DW             = 8,
   parameter int AW             = 4,
   parameter int SYNC_STAGES    = 2,
   parameter bit ACK_ACTIVE_LOW = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cs_n,
   input  logic          wr_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data_in,
   output logic [DW-1:0] data_out,
   output logic          data_oe,
   input  logic [DW-1:0] gpi,
   output logic [DW-1:0] gpo,
   output logic [DW-1:0] prn_data,
   output logic          prn_strobe,
   output logic          prn_init,
   input  logic          prn_busy,
   input  logic          prn_fault,
   input  logic          prn_ack_n
);
   import prt_gpio_pkg::*;

   localparam int DEC_W = 3;

   logic [DEC_W-1:0] addr_lo;
   logic             we_gpo, we_pdata, we_pctl, rd_act;
   logic             ack_clr, ack_flag;
   pstat_t           stat;

   generate
      if (AW < DEC_W) begin : g_bad_aw
         $error("prt_gpio_regs: AW must be at least 3");
      end
      if (AW > DEC_W) begin : g_hi_addr
         logic unused_hi_addr;
         assign unused_hi_addr = ^addr[AW-1:DEC_W];
      end
   endgenerate

   assign addr_lo = addr[DEC_W-1:0];

   prt_addr_dec #(.DEC_W(DEC_W)) u_dec (
      .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n), .addr_lo(addr_lo),
      .we_gpo(we_gpo), .we_pdata(we_pdata), .we_pctl(we_pctl), .rd_act(rd_act)
   );

   prt_out_latch #(.DW(DW)) u_lat (
      .clk(clk), .rst(rst), .we_gpo(we_gpo), .we_pdata(we_pdata),
      .we_pctl(we_pctl), .wdata(data_in), .gpo(gpo), .pdata(prn_data),
      .strobe(prn_strobe), .init(prn_init), .ack_clr(ack_clr)
   );

   prt_ack_capture #(.SYNC_STAGES(SYNC_STAGES), .ACK_ACTIVE_LOW(ACK_ACTIVE_LOW)) u_ack (
      .clk(clk), .rst(rst), .ack_pin(prn_ack_n), .clr(ack_clr), .ack_flag(ack_flag)
   );

   assign stat.busy  = prn_busy;
   assign stat.fault = prn_fault;
   assign stat.ack   = ack_flag;

   prt_rd_mux #(.DW(DW), .DEC_W(DEC_W)) u_mux (
      .rd_act(rd_act), .addr_lo(addr_lo), .gpi(gpi), .stat(stat),
      .data_out(data_out), .data_oe(data_oe)
   );

   AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
      (cs_n || oe_n) |-> (!data_oe && data_out == '0)); // R11
   AST_STAT_PAD: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !oe_n && addr_lo == ADR_PSTAT) |-> (data_out[DW-1:3] == '0)); // R6
   AST_GPO_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !wr_n && addr_lo == ADR_GPOUT) |=> (gpo == $past(data_in))); // R1
   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !wr_n && addr_lo == ADR_PCTL) |=>
         (prn_strobe == $past(data_in[0]) && prn_init == $past(data_in[1]))); // R5
endmodule

// File: tb/prt_gpio_regs_test.sv
module prt_gpio_regs_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
   logic [3:0] addr = '0;
   logic [7:0] data_in = '0;
   logic [7:0] data_out;
   logic       data_oe;
   logic [7:0] gpi = 8'h00;
   logic [7:0] gpo, prn_data;
   logic       prn_strobe, prn_init;
   logic       prn_busy = 1'b0, prn_fault = 1'b0, prn_ack_n = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   prt_gpio_regs uut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n),
      .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
      .gpi(gpi), .gpo(gpo), .prn_data(prn_data), .prn_strobe(prn_strobe),
      .prn_init(prn_init), .prn_busy(prn_busy), .prn_fault(prn_fault),
      .prn_ack_n(prn_ack_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; addr = a; data_in = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   // reads combinationally within the current low clock phase
   task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic oe);
      cs_n = 1'b0; oe_n = 1'b0; addr = a;
      #1;
      d = data_out; oe = data_oe;
      cs_n = 1'b1; oe_n = 1'b1;
      #1;
   endtask

   task automatic t_reset;
      logic [7:0] d; logic oe;
      chk("R10 gpo", gpo, 0);
      chk("R10 prn_data", prn_data, 0);
      chk("R10 strobe/init", {prn_strobe, prn_init}, 0);
      rd(4'd4, d, oe);
      chk("R10 ack flag", d, 0);
      chk("R11 idle oe", data_oe, 0);
      chk("R11 idle data", data_out, 0);
   endtask

   task automatic t_gpio;
      logic [7:0] d; logic oe;
      gpi = 8'hA5;
      @(negedge clk); rd(4'd3, d, oe);
      chk("R2 gpi A5", d, 8'hA5);
      chk("R11 oe on read", oe, 1);
      gpi = 8'h3C;
      rd(4'd3, d, oe);
      chk("R2 gpi 3C", d, 8'h3C);
      wr(4'd4, 8'h5A);
      chk("R3 gpo load", gpo, 8'h5A);
      wr(4'd5, 8'hFF);
      wr(4'd2, 8'h11);
      chk("R3 gpo hold", gpo, 8'h5A);
   endtask

   task automatic t_alias;
      logic [7:0] d; logic oe;
      wr(4'hC, 8'hC3);
      chk("R1 gpo via addr 12", gpo, 8'hC3);
      gpi = 8'h96;
      rd(4'hB, d, oe);
      chk("R1 gpi via addr 11", d, 8'h96);
      wr(4'hD, 8'h7E);
      chk("R1 prn_data via addr 13", prn_data, 8'h7E);
   endtask

   task automatic t_printer_out;
      wr(4'd5, 8'h81);
      chk("R4 prn_data", prn_data, 8'h81);
      wr(4'd4, 8'h00);
      chk("R4 prn_data hold", prn_data, 8'h81);
      wr(4'd6, 8'h01);
      chk("R5 strobe=1 init=0", {prn_strobe, prn_init}, 2'b10);
      wr(4'd6, 8'h02);
      chk("R5 strobe=0 init=1", {prn_strobe, prn_init}, 2'b01);
      wr(4'd6, 8'h03);
      chk("R5 both", {prn_strobe, prn_init}, 2'b11);
   endtask

   task automatic t_status_undef;
      logic [7:0] d; logic oe;
      prn_busy = 1'b1; prn_fault = 1'b0;
      @(negedge clk); rd(4'd4, d, oe);
      chk("R6 busy", d, 8'h01);
      prn_busy = 1'b0; prn_fault = 1'b1;
      rd(4'd4, d, oe);
      chk("R6 fault", d, 8'h02);
      gpi = 8'hFF;
      foreach (d[i]) begin end
      for (int a = 0; a < 8; a++) begin
         if (a != 3 && a != 4) begin
            rd(a[3:0], d, oe);
            chk("R11 undefined read", d, 0);
         end
      end
      prn_fault = 1'b0;
   endtask

   task automatic t_ack_capture;
      logic [7:0] d; logic oe;
      @(negedge clk); prn_ack_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rd(4'd4, d, oe);
      chk("R7 not yet after 2 edges", d[2], 0);
      @(negedge clk);
      rd(4'd4, d, oe);
      chk("R7 set after 3 edges", d, 8'h04);
      wr(4'd6, 8'h00);
      rd(4'd4, d, oe);
      chk("R8 bit2=0 no clear", d[2], 1);
      wr(4'd6, 8'h04);
      rd(4'd4, d, oe);
      chk("R8 clear", d[2], 0);
      repeat (4) @(negedge clk);
      rd(4'd4, d, oe);
      chk("R7 held low no reset", d[2], 0);
      prn_ack_n = 1'b1;
      repeat (5) @(negedge clk);
      rd(4'd4, d, oe);
      chk("R7 rising edge ignored", d[2], 0);
   endtask

   task automatic t_set_wins;
      logic [7:0] d; logic oe;
      @(negedge clk); prn_ack_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; addr = 4'd6; data_in = 8'h04;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      rd(4'd4, d, oe);
      chk("R9 set wins", d[2], 1);
      wr(4'd6, 8'h04);
      rd(4'd4, d, oe);
      chk("R8 clear after", d[2], 0);
      prn_ack_n = 1'b1;
   endtask

   initial begin
      #1;
      t_reset;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_gpio;
      t_alias;
      t_printer_out;
      t_status_undef;
      t_ack_capture;
      t_set_wins;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule